// File: doc/BRIEF.md
# Memory-to-Memory Block Move Engine

The block copies a run of bytes from one region of the address map to another, on its own, without help from the system processor. A command is given as a source address, a destination address, a 24-bit byte count (up to 16 MB) and two space selects. Each select places its side of the transfer in memory space or in I/O space. Both addresses are used directly as given.

The engine first checks that the source and destination have the same byte offset within a 32-bit word. If they differ, it pulses `illegal_o` and touches nothing. Otherwise it moves the data as whole 32-bit words, in bursts. It reads up to four words from the source into a small internal FIFO, then writes the same number of words to the destination. It repeats this until the count is used up, then pulses `done_o` so the next command can be fetched. Byte enables trim the first and last words when the region does not start or end on a word boundary. Because both sides share an offset, every byte keeps its lane.

Top module: `bmm_engine`

## Requirements
- R1: When the low two address bits of source and destination differ, `illegal_o` is high for exactly one cycle, two clock edges after the edge that accepts `start_i`. No bus request is made and `done_o` stays low. This check takes priority over a zero count.
- R2: A byte count of zero with equal offsets gives a one-cycle `done_o`, two edges after acceptance, with no bus request.
- R3: After completion, every destination byte in [dst, dst+count) equals the source byte at the same offset, and bytes just outside that range are unchanged.
- R4: Byte enable bit j covers byte lane j (bits 7:0 = lane 0). The first word enables lanes at or above the start offset. The last word enables lanes below (offset+count) mod 4, or all lanes when that is 0. Every other word enables all four lanes. Reads and writes of word i use the same mask.
- R5: Transfers alternate between a read burst and a write burst of equal length. Each burst is 4 words, except the final one, which carries the remaining words. A write burst never starts before its read burst is complete.
- R6: The number of words moved in each direction is (offset + count + 3) / 4.
- R7: `io_o` equals the source space select during reads and the destination space select during writes (1 = I/O space).
- R8: Word addresses start at the given address with bits 1:0 cleared and rise by 4 for each acknowledged word on each side.
- R9: `done_o` is a one-cycle pulse in the cycle after the last write is acknowledged. `busy_o` is high from the cycle after acceptance through the pulse. `start_i` is ignored while busy.
- R10: Once raised, `req_o` stays high until `ack_i`, with address, direction and byte enables held steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Accept a command while idle |
| src_addr_i | input | 32 | Source byte address |
| dst_addr_i | input | 32 | Destination byte address |
| byte_cnt_i | input | 24 | Number of bytes to move |
| src_io_i | input | 1 | Source in I/O space when 1 |
| dst_io_i | input | 1 | Destination in I/O space when 1 |
| req_o | output | 1 | Bus request |
| we_o | output | 1 | 1 = write, 0 = read |
| addr_o | output | 32 | Word-aligned bus address |
| io_o | output | 1 | Space of the current access |
| be_o | output | 4 | Byte enables |
| wdata_o | output | 32 | Write data |
| rdata_i | input | 32 | Read data, valid with ack_i |
| ack_i | input | 1 | Access complete this cycle |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle illegal-command pulse |

## Verification
The assertions check on every cycle that a request holds steady until it is acknowledged and that the FIFO never overflows or underflows. They also check that a write is only requested when buffered data exists, that a read is only requested when there is room, and that the two exit pulses are single-cycle and never coincide. The bench shows what the assertions cannot. It checks the exact order of reads and writes, with their addresses, spaces and trimmed byte enables, against a behavioural model for aligned, offset, single-word and multi-burst moves. It checks the final memory contents including the bytes at the edges, the pulse timing for zero-count and misaligned commands, and that a start during a move has no effect.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_WRITE,
    ST_DONE,
    ST_ERROR
  } bmm_state_e;
endpackage

// File: rtl/bmm_fifo.sv
module bmm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;

  assign full_o  = (cnt_q == (PW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rp_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/bmm_plan.sv
module bmm_plan #(
  parameter int CW = 24
) (
  input  logic [1:0]    src_lo_i,
  input  logic [1:0]    dst_lo_i,
  input  logic [CW-1:0] cnt_i,
  output logic          misalign_o,
  output logic [CW-1:0] words_o,
  output logic [3:0]    first_be_o,
  output logic [3:0]    last_be_o
);
  logic [CW+1:0] span;
  logic [1:0]    end_lo;

  assign misalign_o = (src_lo_i != dst_lo_i);
  assign span       = {2'b00, cnt_i} + (CW+2)'(src_lo_i) + (CW+2)'(3);
  assign words_o    = span[CW+1:2];
  assign end_lo     = src_lo_i + cnt_i[1:0];

  for (genvar j = 0; j < 4; j++) begin : g_lane
    assign first_be_o[j] = (2'(j) >= src_lo_i);
    assign last_be_o[j]  = (end_lo == 2'd0) || (2'(j) < end_lo);
  end
endmodule

// File: rtl/bmm_seq.sv
module bmm_seq
  import bmm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 24,
  parameter int BURST = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [CW-1:0] byte_cnt_i,
  input  logic          src_io_i,
  input  logic          dst_io_i,
  output logic [1:0]    src_lo_o,
  output logic [1:0]    dst_lo_o,
  output logic [CW-1:0] cnt_o,
  input  logic          misalign_i,
  input  logic [CW-1:0] words_i,
  input  logic [3:0]    first_be_i,
  input  logic [3:0]    last_be_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic          io_o,
  output logic [3:0]    be_o,
  input  logic          ack_i,
  output logic          push_o,
  output logic          pop_o,
  input  logic          fifo_full_i,
  input  logic          fifo_empty_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          illegal_o
);
  localparam int BLW = $clog2(BURST) + 1;

  bmm_state_e    state_q;
  logic [AW-1:0] src_q, dst_q, src_ptr_q, dst_ptr_q;
  logic [CW-1:0] cnt_q, total_q, left_q, rd_idx_q, wr_idx_q, cur_idx;
  logic          sio_q, dio_q;
  logic [BLW-1:0] blen_q, beat_q;
  logic          last_beat;

  function automatic logic [BLW-1:0] clip(input logic [CW-1:0] w);
    return (w >= CW'(BURST)) ? BLW'(BURST) : BLW'(w);
  endfunction

  assign src_lo_o = src_q[1:0];
  assign dst_lo_o = dst_q[1:0];
  assign cnt_o    = cnt_q;

  assign req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign we_o    = (state_q == ST_WRITE);
  assign addr_o  = we_o ? dst_ptr_q : src_ptr_q;
  assign io_o    = we_o ? dio_q : sio_q;
  assign cur_idx = we_o ? wr_idx_q : rd_idx_q;

  always_comb begin
    be_o = 4'hf;
    if (cur_idx == '0)            be_o = be_o & first_be_i;
    if (cur_idx == total_q - 1'b1) be_o = be_o & last_be_i;
  end

  assign push_o    = (state_q == ST_READ) && ack_i;
  assign pop_o     = (state_q == ST_WRITE) && ack_i;
  assign last_beat = (beat_q == blen_q - 1'b1);

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign illegal_o = (state_q == ST_ERROR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      sio_q     <= 1'b0;
      dio_q     <= 1'b0;
      src_ptr_q <= '0;
      dst_ptr_q <= '0;
      total_q   <= '0;
      left_q    <= '0;
      rd_idx_q  <= '0;
      wr_idx_q  <= '0;
      blen_q    <= '0;
      beat_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          src_q   <= src_addr_i;
          dst_q   <= dst_addr_i;
          cnt_q   <= byte_cnt_i;
          sio_q   <= src_io_i;
          dio_q   <= dst_io_i;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          src_ptr_q <= {src_q[AW-1:2], 2'b00};
          dst_ptr_q <= {dst_q[AW-1:2], 2'b00};
          total_q   <= words_i;
          left_q    <= words_i;
          rd_idx_q  <= '0;
          wr_idx_q  <= '0;
          beat_q    <= '0;
          blen_q    <= clip(words_i);
          // alignment fault wins over an empty move
          if (misalign_i)        state_q <= ST_ERROR;
          else if (cnt_q == '0)  state_q <= ST_DONE;
          else                   state_q <= ST_READ;
        end
        ST_READ: if (ack_i) begin
          src_ptr_q <= src_ptr_q + AW'(4);
          rd_idx_q  <= rd_idx_q + 1'b1;
          if (last_beat) begin
            beat_q  <= '0;
            state_q <= ST_WRITE;
          end else begin
            beat_q  <= beat_q + 1'b1;
          end
        end
        ST_WRITE: if (ack_i) begin
          dst_ptr_q <= dst_ptr_q + AW'(4);
          wr_idx_q  <= wr_idx_q + 1'b1;
          left_q    <= left_q - 1'b1;
          if (last_beat) begin
            beat_q  <= '0;
            blen_q  <= clip(left_q - 1'b1);
            state_q <= (left_q == CW'(1)) ? ST_DONE : ST_READ;
          end else begin
            beat_q  <= beat_q + 1'b1;
          end
        end
        ST_DONE:  state_q <= ST_IDLE;
        ST_ERROR: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o) && $stable(be_o)));
  assert_write_has_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o) |-> !fifo_empty_i);
  assert_read_has_room_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !we_o) |-> !fifo_full_i);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_illegal_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> (!illegal_o && !req_o));
  assert_exit_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));
endmodule

// File: rtl/bmm_engine.sv
module bmm_engine #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 24,
  parameter int BURST = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [CW-1:0] byte_cnt_i,
  input  logic          src_io_i,
  input  logic          dst_io_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic          io_o,
  output logic [3:0]    be_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  input  logic          ack_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          illegal_o
);
  logic [1:0]    src_lo, dst_lo;
  logic [CW-1:0] cnt, words;
  logic          misalign;
  logic [3:0]    first_be, last_be;
  logic          push, pop, full, empty;

  bmm_plan #(.CW(CW)) u_plan (
    .src_lo_i   (src_lo),
    .dst_lo_i   (dst_lo),
    .cnt_i      (cnt),
    .misalign_o (misalign),
    .words_o    (words),
    .first_be_o (first_be),
    .last_be_o  (last_be)
  );

  bmm_seq #(.AW(AW), .CW(CW), .BURST(BURST)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .src_addr_i   (src_addr_i),
    .dst_addr_i   (dst_addr_i),
    .byte_cnt_i   (byte_cnt_i),
    .src_io_i     (src_io_i),
    .dst_io_i     (dst_io_i),
    .src_lo_o     (src_lo),
    .dst_lo_o     (dst_lo),
    .cnt_o        (cnt),
    .misalign_i   (misalign),
    .words_i      (words),
    .first_be_i   (first_be),
    .last_be_i    (last_be),
    .req_o        (req_o),
    .we_o         (we_o),
    .addr_o       (addr_o),
    .io_o         (io_o),
    .be_o         (be_o),
    .ack_i        (ack_i),
    .push_o       (push),
    .pop_o        (pop),
    .fifo_full_i  (full),
    .fifo_empty_i (empty),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .illegal_o    (illegal_o)
  );

  bmm_fifo #(.W(DW), .DEPTH(BURST)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (rdata_i),
    .pop_i   (pop),
    .dout_o  (wdata_o),
    .full_o  (full),
    .empty_o (empty)
  );
endmodule

// File: tb/bmm_engine_test.sv
`timescale 1ns/1ps
module bmm_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_a = '0, dst_a = '0;
  logic [23:0] cnt = '0;
  logic        sio = 1'b0, dio = 1'b0;
  logic        req, we, io, ack = 1'b0, busy, done, ill;
  logic [31:0] addr, wdata, rdata;
  logic [3:0]  be;

  int errors = 0;
  int checks = 0;
  int ops_seen = 0;
  int wt = 0;

  logic [7:0] mem_m  [1024];
  logic [7:0] mem_io [1024];
  logic [69:0] expq [$];   // {we, io, be, addr, data}

  always #5 clk = ~clk;

  bmm_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_addr_i(src_a), .dst_addr_i(dst_a), .byte_cnt_i(cnt),
    .src_io_i(sio), .dst_io_i(dio),
    .req_o(req), .we_o(we), .addr_o(addr), .io_o(io), .be_o(be),
    .wdata_o(wdata), .rdata_i(rdata), .ack_i(ack),
    .busy_o(busy), .done_o(done), .illegal_o(ill)
  );

  function automatic logic [7:0] rdb(input logic sp, input logic [31:0] a);
    return sp ? mem_io[a[9:0]] : mem_m[a[9:0]];
  endfunction

  function automatic logic [31:0] rdw(input logic sp, input logic [31:0] a);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) w[8*j +: 8] = rdb(sp, {a[31:2], 2'b00} + 32'(j));
    return w;
  endfunction

  assign rdata = rdw(io, addr);

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input logic [69:0] act, input logic [69:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req_tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // bus slave with variable wait, compares every acknowledged access to the model
  always @(posedge clk) begin
    if (req && ack) begin
      ops_seen++;
      if (expq.size() == 0) begin
        chk(1'b0, "R5", "unexpected bus access", {we, io, be, addr, wdata}, '0);
      end else begin
        logic [69:0] e;
        logic [69:0] a;
        e = expq.pop_front();
        a = {we, io, be, addr, (we ? wdata : e[31:0])};
        chk(a == e, "R4/R5/R7/R8", "bus access", a, e);
      end
      if (we) begin
        for (int j = 0; j < 4; j++)
          if (be[j]) begin
            if (io) mem_io[addr[9:0] + 10'(j)] = wdata[8*j +: 8];
            else    mem_m[addr[9:0] + 10'(j)]  = wdata[8*j +: 8];
          end
      end
    end
    ack <= 1'b0;
    if (req && !ack) begin
      if (wt == 0) begin
        ack <= 1'b1;
        wt  <= int'($urandom % 3);
      end else begin
        wt <= wt - 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", '0, '0);
    finish_run();
  end

  function automatic logic [3:0] lane_mask(input logic [31:0] wa, input logic [31:0] base,
                                           input logic [23:0] n);
    logic [3:0] m;
    for (int j = 0; j < 4; j++)
      m[j] = ((wa + 32'(j)) >= base) && ((wa + 32'(j)) < base + 32'(n));
    return m;
  endfunction

  task automatic run_cmd(input logic [31:0] s, input logic [31:0] d, input logic [23:0] n,
                         input logic si, input logic di, input bit poke);
    int total;
    int k;
    int cyc;
    int ops0;
    bit mis;
    logic [7:0] snap [1024];
    logic [31:0] sa, da;
    mis   = (s[1:0] != d[1:0]);
    sa    = {s[31:2], 2'b00};
    da    = {d[31:2], 2'b00};
    total = mis ? 0 : int'((32'(n) + 32'(s[1:0]) + 3) >> 2);
    for (int i = 0; i < 1024; i++) snap[i] = di ? mem_io[i] : mem_m[i];
    k = 0;
    while (k < total) begin
      int b;
      b = (total - k > 4) ? 4 : total - k;
      for (int i = 0; i < b; i++)
        expq.push_back({1'b0, si, lane_mask(sa + 32'(4*(k+i)), s, n), sa + 32'(4*(k+i)), 32'h0});
      for (int i = 0; i < b; i++)
        expq.push_back({1'b1, di, lane_mask(da + 32'(4*(k+i)), d, n), da + 32'(4*(k+i)),
                        rdw(si, sa + 32'(4*(k+i)))});
      k += b;
    end
    ops0 = ops_seen;
    @(negedge clk);
    src_a = s; dst_a = d; cnt = n; sio = si; dio = di; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !ill, "R9", "busy after accept", {67'b0, busy, done, ill}, 70'b100);
    cyc = 0;
    while (!done && !ill && cyc < 20000) begin
      if (poke && cyc == 3) begin
        src_a = 32'h1; dst_a = 32'h2; cnt = 24'd8; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (mis) begin
      chk(ill && !done && cyc == 1, "R1", "illegal pulse timing", 70'(cyc), 70'd1);
      chk(ops_seen == ops0, "R1", "no bus access on illegal", 70'(ops_seen - ops0), 70'd0);
    end else if (n == 0) begin
      chk(done && !ill && cyc == 1, "R2", "zero-count done timing", 70'(cyc), 70'd1);
      chk(ops_seen == ops0, "R2", "no bus access on zero count", 70'(ops_seen - ops0), 70'd0);
    end else begin
      chk(done && !ill, "R9", "done raised", {68'b0, done, ill}, 70'b10);
      chk(expq.size() == 0, "R6", "all modelled accesses seen", 70'(expq.size()), 70'd0);
      chk(ops_seen - ops0 == 2 * total, "R6", "word count", 70'(ops_seen - ops0), 70'(2 * total));
      begin
        bit ok;
        ok = 1'b1;
        for (int i = -4; i < int'(n) + 4; i++) begin
          logic [31:0] a;
          logic [7:0] got, want;
          a    = d + 32'(i);
          got  = rdb(di, a);
          want = (i >= 0 && i < int'(n)) ? rdb(si, s + 32'(i)) : snap[a[9:0]];
          if (got !== want) ok = 1'b0;
        end
        chk(ok, "R3", "destination bytes and edges", 70'(n), 70'(n));
      end
    end
    expq.delete();
    @(negedge clk);
    chk(!done && !ill && !busy, "R9", "pulse is one cycle, idle after",
        {67'b0, busy, done, ill}, 70'b0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem_m[i]  = 8'(i * 7 + 3);
      mem_io[i] = 8'(i * 13 + 91);
    end
    repeat (3) @(negedge clk);
    chk(!req && !busy && !done && !ill, "R9", "reset state",
        {66'b0, req, busy, done, ill}, 70'b0);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmd(32'h000, 32'h100, 24'd64, 1'b0, 1'b0, 1'b0); // aligned, four full bursts
    run_cmd(32'h041, 32'h181, 24'd10, 1'b0, 1'b0, 1'b0); // shared offset 1
    run_cmd(32'h022, 32'h2A2, 24'd1,  1'b0, 1'b0, 1'b0); // single byte in one word
    run_cmd(32'h080, 32'h300, 24'd22, 1'b1, 1'b0, 1'b0); // I/O source, short last burst
    run_cmd(32'h0C3, 32'h203, 24'd37, 1'b0, 1'b1, 1'b0); // I/O destination, offset 3
    run_cmd(32'h010, 32'h110, 24'd0,  1'b0, 1'b0, 1'b0); // R2 zero count
    run_cmd(32'h001, 32'h102, 24'd16, 1'b0, 1'b0, 1'b0); // R1 misaligned
    run_cmd(32'h002, 32'h101, 24'd0,  1'b0, 1'b0, 1'b0); // R1 misaligned beats zero count
    run_cmd(32'h140, 32'h3C0, 24'd40, 1'b0, 1'b0, 1'b1); // R9 start while busy ignored
    finish_run();
  end
endmodule